// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-interrupt flags and the matching enable bits for three timer/counters. Each of the eight sources delivers a one-cycle event pulse: an overflow, a compare match or an input capture. The pulse sets the flag for that source, and the flag stays set until it is cleared. Software clears a flag by writing a one to its bit. Hardware clears it when the processor acknowledges the interrupt vector for that source.

Each flag drives its own request line. A request is raised only while three things hold at once: the global interrupt bit is set, the enable for that source is set, and its flag is set. Software reaches both registers through a small read/write port with a single select bit. The timer counters and the processor's vector dispatch sit outside this block.

Top module: `timer_irq_flags`

## Requirements
- R1: After reset, both registers read zero and every request line is low.
- R2: Flag bit positions are: 7 timer1 overflow, 6 timer1 compare A, 5 timer1 compare B, 4 timer2 overflow, 3 timer1 capture, 2 timer2 compare, 1 timer0 overflow, 0 timer0 compare. A pulse on evtPulse[k] sets flag k at the next clock edge. For bit 7 this holds only while pwmMode is 0.
- R3: While pwmMode is 1, flag 7 is set by t1LeaveZero, which pulses when timer1 leaves count zero, and evtPulse[7] has no effect. While pwmMode is 0, t1LeaveZero has no effect.
- R4: A write with regSel=0 clears every flag whose wrData bit is 1. Flags whose wrData bit is 0 keep their state.
- R5: vecAck is one-hot and aligned to the flag bits. A set bit k clears flag k only.
- R6: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R7: irqReq[k] is globalIe AND enable[k] AND flag[k]. It follows the register state with no added register stage.
- R8: A write with regSel=1 loads the enable register. The enable bits use the same positions as the flag bits, and the value reads back with regSel=1.
- R9: rdData shows the register state as it stands before the clock edge, so a read in the same cycle as a clear still returns the flag as set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| regWr | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| evtPulse | input | 8 | One-cycle event pulses, aligned to the flag bits |
| t1LeaveZero | input | 1 | Pulse when timer1 leaves count zero |
| pwmMode | input | 1 | Selects the timer1 overflow set source |
| vecAck | input | 8 | One-hot vector acknowledge |
| globalIe | input | 1 | Global interrupt enable |
| irqReq | output | 8 | Per-source interrupt requests |

## Verification
A wrong flag state shows up on rdData at the first idle cycle after the offending edge. If that source's enable and globalIe are both set, it also shows on the matching irqReq line in that same cycle. A flag that drops when it should stay set, for example when a set and a clear collide, therefore appears one cycle after the collision. A bad enable bit stays hidden on irqReq until its flag rises, so enables are also read back directly.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int SRC_W = 8;
  // bit positions that the vector logic decodes
  localparam int T1_OVF = 7;
  localparam int T1_CMPA = 6;
  localparam int T1_CMPB = 5;
  localparam int T2_OVF = 4;
  localparam int T1_CAP = 3;
  localparam int T2_CMP = 2;
  localparam int T0_OVF = 1;
  localparam int T0_CMP = 0;

  typedef struct packed {
    logic [SRC_W-1:0] setMask;
    logic [SRC_W-1:0] clrMask;
    logic             enLoad;
    logic [SRC_W-1:0] enData;
  } tfc_strobe_t;
endpackage

// File: rtl/tfc_ctrl.sv
module tfc_ctrl
  import tfc_pkg::*;
#(
  parameter int W = SRC_W,
  parameter int PWM_BIT = T1_OVF
) (
  input  logic         regSel,
  input  logic         regWr,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] evtPulse,
  input  logic         t1LeaveZero,
  input  logic         pwmMode,
  input  logic [W-1:0] vecAck,
  output tfc_strobe_t  strobe
);
  logic [W-1:0] setVec;
  logic [W-1:0] swClr;

  for (genvar i = 0; i < W; i++) begin : g_set
    if (i == PWM_BIT) begin : g_pwm
      assign setVec[i] = pwmMode ? t1LeaveZero : evtPulse[i];
    end else begin : g_plain
      assign setVec[i] = evtPulse[i];
    end
  end

  assign swClr = (regWr && !regSel) ? wrData : '0;

  always_comb begin
    strobe.setMask = setVec;
    strobe.clrMask = swClr | vecAck;
    strobe.enLoad  = regWr && regSel;
    strobe.enData  = wrData;
  end
endmodule

// File: rtl/tfc_dp.sv
module tfc_dp
  import tfc_pkg::*;
#(
  parameter int W = SRC_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  tfc_strobe_t  strobe,
  input  logic         regSel,
  input  logic         globalIe,
  output logic [W-1:0] flagQ,
  output logic [W-1:0] enQ,
  output logic [W-1:0] rdData,
  output logic [W-1:0] irqReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      // set has priority so that no event is lost
      flagQ <= (flagQ & ~strobe.clrMask) | strobe.setMask;
      if (strobe.enLoad) enQ <= strobe.enData;
    end
  end

  assign rdData = regSel ? enQ : flagQ;
  assign irqReq = flagQ & enQ & {W{globalIe}};
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import tfc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic [SRC_W-1:0] wrData,
  output logic [SRC_W-1:0] rdData,
  input  logic [SRC_W-1:0] evtPulse,
  input  logic             t1LeaveZero,
  input  logic             pwmMode,
  input  logic [SRC_W-1:0] vecAck,
  input  logic             globalIe,
  output logic [SRC_W-1:0] irqReq
);
  tfc_strobe_t strobe;
  logic [SRC_W-1:0] flagQ;
  logic [SRC_W-1:0] enQ;

  tfc_ctrl #(.W(SRC_W), .PWM_BIT(T1_OVF)) u_ctrl (
    .regSel(regSel), .regWr(regWr), .wrData(wrData), .evtPulse(evtPulse),
    .t1LeaveZero(t1LeaveZero), .pwmMode(pwmMode), .vecAck(vecAck),
    .strobe(strobe)
  );

  tfc_dp #(.W(SRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .globalIe(globalIe), .flagQ(flagQ), .enQ(enQ), .rdData(rdData),
    .irqReq(irqReq)
  );
endmodule

// File: rtl/tfc_chk.sv
module tfc_chk
  import tfc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regSel,
  input logic             regWr,
  input logic [SRC_W-1:0] wrData,
  input logic [SRC_W-1:0] evtPulse,
  input logic             t1LeaveZero,
  input logic             pwmMode,
  input logic [SRC_W-1:0] vecAck,
  input logic             globalIe,
  input logic [SRC_W-1:0] irqReq,
  input logic [SRC_W-1:0] flagQ
);
  localparam int LW = SRC_W - 1;

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse[LW-1:0] != '0) |=>
      ((flagQ[LW-1:0] & $past(evtPulse[LW-1:0])) == $past(evtPulse[LW-1:0])));

  // R3
  pwm_leave_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwmMode && t1LeaveZero) |=> flagQ[T1_OVF]);

  // R4
  wr_one_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && !regSel && evtPulse == '0 && !t1LeaveZero) |=>
      ((flagQ & $past(wrData)) == '0));

  // R5
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($onehot0(vecAck) && vecAck != '0 && evtPulse == '0 && !t1LeaveZero) |=>
      ((flagQ & $past(vecAck)) == '0));

  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(vecAck));

  // R7
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq != '0) |-> (globalIe && (irqReq & ~flagQ) == '0));

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr && vecAck == '0 && evtPulse == '0 && !t1LeaveZero) |=> $stable(flagQ));
endmodule

bind timer_irq_flags tfc_chk u_chk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .wrData(wrData),
  .evtPulse(evtPulse), .t1LeaveZero(t1LeaveZero), .pwmMode(pwmMode),
  .vecAck(vecAck), .globalIe(globalIe), .irqReq(irqReq), .flagQ(flagQ)
);

// File: tb/sim_timer_irq_flags.sv
module sim_timer_irq_flags;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, regWr = 1'b0;
  logic [7:0] wrData = '0, evtPulse = '0, vecAck = '0;
  logic t1LeaveZero = 1'b0, pwmMode = 1'b0, globalIe = 1'b0;
  logic [7:0] rdData, irqReq;
  int nChk = 0, nBad = 0;

  always #4 clk = ~clk;

  timer_irq_flags u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .wrData(wrData),
    .rdData(rdData), .evtPulse(evtPulse), .t1LeaveZero(t1LeaveZero),
    .pwmMode(pwmMode), .vecAck(vecAck), .globalIe(globalIe), .irqReq(irqReq)
  );

  // fields: sel wr wd ev ack gie pwm lz | expFlags expIrq
  localparam int NV = 17;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00,8'h01,8'h00,1'b1,1'b0,1'b0, 8'h01,8'h00}, // R2 t0 compare
    {1'b1,1'b1,8'hFF,8'h00,8'h00,1'b1,1'b0,1'b0, 8'h01,8'h01}, // R8 R7
    {1'b0,1'b0,8'h00,8'h7E,8'h00,1'b1,1'b0,1'b0, 8'h7F,8'h7F}, // R2
    {1'b0,1'b0,8'h00,8'h80,8'h00,1'b1,1'b0,1'b0, 8'hFF,8'hFF}, // R2 t1 wrap
    {1'b0,1'b1,8'h0F,8'h00,8'h00,1'b1,1'b0,1'b0, 8'hF0,8'hF0}, // R4
    {1'b0,1'b1,8'h00,8'h00,8'h00,1'b1,1'b0,1'b0, 8'hF0,8'hF0}, // R4 zero write
    {1'b0,1'b0,8'h00,8'h00,8'h20,1'b1,1'b0,1'b0, 8'hD0,8'hD0}, // R5
    {1'b0,1'b0,8'h00,8'h00,8'h00,1'b0,1'b0,1'b0, 8'hD0,8'h00}, // R7 gie off
    {1'b1,1'b1,8'h50,8'h00,8'h00,1'b1,1'b0,1'b0, 8'hD0,8'h50}, // R8 R7
    {1'b0,1'b0,8'h00,8'h10,8'h10,1'b1,1'b0,1'b0, 8'hD0,8'h50}, // R6 ack vs set
    {1'b0,1'b1,8'h40,8'h40,8'h00,1'b1,1'b0,1'b0, 8'hD0,8'h50}, // R6 write vs set
    {1'b0,1'b1,8'h80,8'h00,8'h00,1'b1,1'b0,1'b0, 8'h50,8'h50}, // R4
    {1'b0,1'b0,8'h00,8'h80,8'h00,1'b1,1'b1,1'b0, 8'h50,8'h50}, // R3 wrap ignored
    {1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,1'b1,1'b1, 8'hD0,8'h50}, // R3 leave zero
    {1'b0,1'b1,8'hFF,8'h00,8'h00,1'b1,1'b0,1'b0, 8'h00,8'h00}, // R4
    {1'b0,1'b0,8'h00,8'h00,8'h00,1'b1,1'b0,1'b1, 8'h00,8'h00}, // R3 lz ignored
    {1'b0,1'b0,8'h00,8'h08,8'h00,1'b1,1'b0,1'b0, 8'h08,8'h00}  // R2 capture
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    regSel = 1'b0; regWr = 1'b0; wrData = '0; evtPulse = '0;
    vecAck = '0; t1LeaveZero = 1'b0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flags", rdData, 8'h00);
    check("R1 irq", irqReq, 8'h00);
    regSel = 1'b1; #1;
    check("R1 enables", rdData, 8'h00);
    regSel = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {regSel, regWr, wrData, evtPulse, vecAck, globalIe, pwmMode, t1LeaveZero} = VEC[i][44:16];
      @(negedge clk);
      idle();
      #1;
      check($sformatf("R2-table step %0d flags", i), rdData, VEC[i][15:8]);
      check($sformatf("R7 step %0d irq", i), irqReq, VEC[i][7:0]);
    end

    // R8 enable readback
    regSel = 1'b1; #1;
    check("R8 enable readback", rdData, 8'h50);
    regSel = 1'b0;
    @(negedge clk);

    // R9 read in clear cycle shows old value
    regWr = 1'b1; wrData = 8'h08; #1;
    check("R9 read before clear", rdData, 8'h08);
    @(negedge clk); idle(); #1;
    check("R9 cleared after edge", rdData, 8'h00);

    // R5 ack clears only its own bit
    evtPulse = 8'h03;
    @(negedge clk); idle();
    vecAck = 8'h01;
    #1 check("R9 read before ack", rdData, 8'h03);
    @(negedge clk); idle(); #1;
    check("R5 ack only own bit", rdData, 8'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule